// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block is the read side of a NOR-style storage device. A 16-bit configuration word sets how the read path behaves: synchronous burst or plain asynchronous access, a first-access latency of 2 to 7 clocks, and a burst of 4, 8 or 16 words or an endless stream. It also sets whether a fixed burst wraps inside its aligned block or runs on linearly, whether each word stays on the bus for one or two clocks, and how the READY_WAIT pin behaves. A host loads the word, asserts chip-enable, and pulses address-valid with a start address. The engine then counts out the latency and streams words from its internal array.

The control is one state machine with four named states. ST_IDLE waits for a start. ST_LAT counts down the latency. ST_DATA presents words. ST_GAP is a single idle output cycle inserted when a linear fixed-length burst crosses a 16-word boundary. The named transitions are: START (ST_IDLE to ST_LAT on address-valid with chip-enable, synchronous mode and a legal configuration), LAT_DONE (ST_LAT to ST_DATA when the count reaches one), TO_GAP (ST_DATA to ST_GAP at the end of a word whose successor begins a new 16-word block), GAP_DONE (ST_GAP to ST_DATA), COUNT_DONE (ST_DATA to ST_IDLE after the last word of a fixed burst) and CE_ABORT (any busy state to ST_IDLE when chip-enable drops). A small array write port fills the storage. Programming and erasing are not part of this block.

Top module: `burst_read_engine`

## Requirements
- R1: The configuration register resets to 16'h3D5F and loads from cfg_wdata on cfg_we only while the engine is idle. A write during a burst is ignored. Field positions: [15] async mode, [13:11] latency code, [10] wait polarity (1 = active high), [9] two-clock data hold, [8] early wait, [6] rising edge (1) or falling (0), [4] ready function (1) or wait function (0), [3] no-wrap (1) or wrap (0), [2:0] length code. Bits 14, 7 and 5 are reserved and must be 0.
- R2: With latency code L (2 to 7), the first word is on dq_out with dq_oe high in the L-th cycle after the edge that samples address-valid. dq_oe stays low before that cycle.
- R3: Length codes 1, 2 and 3 give bursts of 4, 8 and 16 words. After the last word, dq_oe goes low and dq_out is 0.
- R4: A wrapping fixed burst steps through addresses inside its aligned 4-, 8- or 16-word block, modulo the block size.
- R5: Length code 7 gives a continuous burst that ignores bit 3. The address rolls from the last array word to 0.
- R6: With bit 9 set, every word stays on dq_out for two cycles. Otherwise it stays for one.
- R7: In a linear fixed burst, when the next address starts a new 16-word block, one extra cycle is inserted. During that cycle dq_oe stays high and dq_out keeps the previous word.
- R8: With bit 8 clear, the wait condition is active in every latency cycle and in the inserted cycle. With bit 8 set, the wait condition is active one cycle earlier: in all latency cycles but the last, and in the final cycle of the word before the inserted cycle.
- R9: In wait function, rdy_wait equals the wait condition when bit 10 is 1 and its inverse when bit 10 is 0. The wait condition is inactive outside a burst. In ready function, rdy_wait is constantly 1.
- R10: cfg_err is high when the latency code is below 2, when the length code is not 1, 2, 3 or 7, when a reserved bit is set, or when latency 2, two-clock hold and early wait are combined. While cfg_err is high, no burst starts.
- R11: Dropping chip_en during a burst returns the engine to idle at the next edge, so dq_oe is low from the next cycle on.
- R12: With bit 15 set, no burst starts. While chip_en is high, dq_oe is 1 and dq_out shows the array word at start_addr, with no clock involved.
- R13: launch_fall is 1 exactly when bit 6 of the loaded configuration is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | 16 | Configuration word |
| arr_we | input | 1 | Array fill write enable |
| arr_waddr | input | AW | Array fill address |
| arr_wdata | input | DW | Array fill data |
| chip_en | input | 1 | Chip enable, active high |
| addr_valid | input | 1 | Start address valid |
| start_addr | input | AW | Burst start / async read address |
| dq_out | output | DW | Output data, 0 when not driven |
| dq_oe | output | 1 | Output enable; low means high impedance |
| rdy_wait | output | 1 | Configurable ready / wait pin |
| cfg_err | output | 1 | Unsupported configuration loaded |
| launch_fall | output | 1 | Output stage launches on the falling edge |

## Verification
The hardest situation to reach is the inserted boundary cycle combined with early wait and two-clock hold. It needs a linear fixed burst that starts a few words below a 16-word boundary, with a latency legal for that combination. The stimulus table starts 8-word and 4-word linear bursts at addresses 13, 14 and 29, in both wait timings and polarities, so the wait pulse has to land on the second half of the last word before the gap. An ignored mid-burst configuration write is made visible by changing the edge bit and the latency, and then watching launch_fall and the latency of the next burst.

// File: rtl/brst_pkg.sv
package brst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_DATA,
        ST_GAP
    } state_t;

    typedef struct packed {
        logic       async_md;
        logic [2:0] lat;
        logic       wait_hi;
        logic       hold2;
        logic       wait_early;
        logic       fall_edge;
        logic       wait_fn;
        logic       wrap_en;
        logic [2:0] len_code;
    } cfg_t;

    localparam logic [15:0] CFG_RESET = 16'h3D5F;
    localparam logic [2:0]  LEN_CONT  = 3'b111;

    function automatic cfg_t cfg_decode(input logic [15:0] w);
        cfg_t c;
        c.async_md   = w[15];
        c.lat        = w[13:11];
        c.wait_hi    = w[10];
        c.hold2      = w[9];
        c.wait_early = w[8];
        c.fall_edge  = ~w[6];
        c.wait_fn    = ~w[4];
        c.wrap_en    = ~w[3];
        c.len_code   = w[2:0];
        return c;
    endfunction

endpackage

// File: rtl/brst_cfg_reg.sv
module brst_cfg_reg
    import brst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    input  logic        allow,
    output cfg_t        cfg,
    output logic        err
);
    logic [15:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= CFG_RESET;
        else if (we && allow)
            word_q <= wdata;
    end

    always_comb begin
        cfg = cfg_decode(word_q);
        err = 1'b0;
        if (word_q[13:11] < 3'd2)
            err = 1'b1;
        if (!(word_q[2:0] inside {3'd1, 3'd2, 3'd3, LEN_CONT}))
            err = 1'b1;
        if (word_q[14] || word_q[7] || word_q[5])
            err = 1'b1;
        if (word_q[13:11] == 3'd2 && word_q[9] && word_q[8])
            err = 1'b1;
    end
endmodule

// File: rtl/brst_addr_gen.sv
module brst_addr_gen
    import brst_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0] addr,
    input  logic [2:0]    len_code,
    input  logic          wrap_en,
    output logic [AW-1:0] next_addr,
    output logic          gap_need
);
    localparam logic [AW-1:0] ONE = AW'(1);
    logic [AW-1:0] mask;
    logic          fixed;

    always_comb begin
        fixed = (len_code != LEN_CONT);
        unique case (len_code)
            3'd1:    mask = AW'(3);
            3'd2:    mask = AW'(7);
            3'd3:    mask = AW'(15);
            default: mask = '1;
        endcase
        if (fixed && wrap_en)
            next_addr = (addr & ~mask) | ((addr + ONE) & mask);
        else
            next_addr = addr + ONE;
        gap_need = fixed && !wrap_en && (next_addr[3:0] == 4'd0);
    end
endmodule

// File: rtl/brst_array.sv
module brst_array #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
    import brst_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_wdata,
    input  logic          arr_we,
    input  logic [AW-1:0] arr_waddr,
    input  logic [DW-1:0] arr_wdata,
    input  logic          chip_en,
    input  logic          addr_valid,
    input  logic [AW-1:0] start_addr,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          rdy_wait,
    output logic          cfg_err,
    output logic          launch_fall
);
    cfg_t          cfg;
    state_t        state_q, nxt;
    logic [2:0]    cnt_q;
    logic [AW-1:0] addr_q, next_addr, rd_addr;
    logic          phase_q;
    logic [4:0]    words_q, burst_len;
    logic          gap_need, start, word_end, last_word, fixed_len, wait_act;
    logic [DW-1:0] rd_data;

    brst_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .allow (state_q == ST_IDLE),
        .cfg   (cfg),
        .err   (cfg_err)
    );

    brst_addr_gen #(.AW(AW)) u_agen (
        .addr      (addr_q),
        .len_code  (cfg.len_code),
        .wrap_en   (cfg.wrap_en),
        .next_addr (next_addr),
        .gap_need  (gap_need)
    );

    brst_array #(.DW(DW), .DEPTH(DEPTH)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // burst bookkeeping derived from configuration
    always_comb begin
        fixed_len = (cfg.len_code != LEN_CONT);
        unique case (cfg.len_code)
            3'd1:    burst_len = 5'd4;
            3'd2:    burst_len = 5'd8;
            3'd3:    burst_len = 5'd16;
            default: burst_len = 5'd0;
        endcase
        start     = chip_en && addr_valid && !cfg.async_md && !cfg_err;
        word_end  = !cfg.hold2 || phase_q;
        last_word = fixed_len && (words_q == burst_len - 5'd1);
    end

    // next-state logic: START, LAT_DONE, TO_GAP, GAP_DONE, COUNT_DONE, CE_ABORT
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (start) nxt = ST_LAT;
            ST_LAT: begin
                if (!chip_en)          nxt = ST_IDLE;
                else if (cnt_q == 3'd1) nxt = ST_DATA;
            end
            ST_DATA: begin
                if (!chip_en)     nxt = ST_IDLE;
                else if (word_end) begin
                    if (last_word)     nxt = ST_IDLE;
                    else if (gap_need) nxt = ST_GAP;
                end
            end
            ST_GAP: nxt = chip_en ? ST_DATA : ST_IDLE;
        endcase
    end

    // state register and burst datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            phase_q <= 1'b0;
            words_q <= '0;
        end else begin
            state_q <= nxt;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cnt_q   <= cfg.lat;
                    addr_q  <= start_addr;
                    phase_q <= 1'b0;
                    words_q <= '0;
                end
                ST_LAT: cnt_q <= cnt_q - 3'd1;
                ST_DATA: begin
                    if (word_end) begin
                        phase_q <= 1'b0;
                        words_q <= words_q + 5'd1;
                        if (nxt == ST_DATA)
                            addr_q <= next_addr;
                    end else begin
                        phase_q <= 1'b1;
                    end
                end
                ST_GAP: addr_q <= next_addr;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_addr  = (state_q == ST_IDLE) ? start_addr : addr_q;
        dq_oe    = 1'b0;
        wait_act = 1'b0;
        unique case (state_q)
            ST_IDLE: dq_oe = cfg.async_md && chip_en;
            ST_LAT:  wait_act = cfg.wait_early ? (cnt_q > 3'd1) : 1'b1;
            ST_DATA: begin
                dq_oe    = 1'b1;
                wait_act = cfg.wait_early && (nxt == ST_GAP);
            end
            ST_GAP: begin
                dq_oe    = 1'b1;
                wait_act = !cfg.wait_early;
            end
        endcase
        dq_out      = dq_oe ? rd_data : '0;
        rdy_wait    = cfg.wait_fn ? (wait_act ~^ cfg.wait_hi) : 1'b1;
        launch_fall = cfg.fall_edge;
    end
endmodule

// File: rtl/brst_checker.sv
module brst_checker
    import brst_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chip_en,
    input logic          addr_valid,
    input logic          cfg_err,
    input logic [DW-1:0] dq_out,
    input state_t        state_q,
    input logic [2:0]    cnt_q,
    input cfg_t          cfg
);
    AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cfg_err && chip_en && addr_valid) |=> (state_q == ST_IDLE)); // R10
    AST_CE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && state_q != ST_IDLE) |=> (state_q == ST_IDLE)); // R11
    AST_LATENCY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAT && cnt_q > 3'd1 && chip_en) |=> (state_q == ST_LAT)); // R2
    AST_GAP_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> $stable(dq_out)); // R7
    AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |=> (state_q != ST_GAP)); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(cfg)); // R1
endmodule

bind burst_read_engine brst_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .addr_valid (addr_valid),
    .cfg_err    (cfg_err),
    .dq_out     (dq_out),
    .state_q    (state_q),
    .cnt_q      (cnt_q),
    .cfg        (cfg)
);

// File: tb/tb_burst_read_engine.sv
`timescale 1ns/1ps
module tb_burst_read_engine;
    localparam int DW = 16;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int NC = 44;

    typedef struct packed {
        logic [15:0] cfg;
        logic [5:0]  addr;
        logic [15:0] tag;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'h1C49, 6'd5,  "R2"},
        '{16'h2542, 6'd13, "R4"},
        '{16'h144A, 6'd13, "R7"},
        '{16'h1B4A, 6'd29, "R8"},
        '{16'h2D47, 6'd62, "R5"},
        '{16'h3653, 6'd37, "R6"},
        '{16'h3849, 6'd14, "R3"}
    };

    logic          clk = 0, rst_n = 0;
    logic          cfg_we = 0, arr_we = 0, chip_en = 0, addr_valid = 0;
    logic [15:0]   cfg_wdata = '0;
    logic [AW-1:0] arr_waddr = '0, start_addr = '0;
    logic [DW-1:0] arr_wdata = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, rdy_wait, cfg_err, launch_fall;

    int n_chk = 0, n_fail = 0;
    bit exp_oe [64];
    bit exp_act [64];
    logic [15:0] exp_dq [64];

    always #5 clk = ~clk;

    burst_read_engine #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

    function automatic logic [15:0] memval(input int a);
        return 16'hA000 ^ 16'(a * 257);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] w);
        cfg_we = 1; cfg_wdata = w;
        tick();
        cfg_we = 0;
    endtask

    task automatic build_model(input logic [15:0] c, input int addr);
        int lat, hold, lc, n, idx, a, nx, mask;
        bit early, wrapb, fixed, gap;
        lat = int'(c[13:11]); hold = c[9] ? 2 : 1; early = c[8];
        wrapb = !c[3]; lc = int'(c[2:0]); fixed = (lc != 7);
        n = fixed ? (4 << (lc - 1)) : 64;
        mask = fixed ? (4 << (lc - 1)) - 1 : 63;
        for (int i = 0; i < 64; i++) begin
            exp_oe[i] = 0; exp_act[i] = 0; exp_dq[i] = '0;
        end
        idx = 0;
        for (int t = 0; t < lat; t++) begin
            exp_act[idx] = early ? (t <= lat - 2) : 1'b1;
            idx++;
        end
        a = addr;
        for (int i = 0; i < n && idx < 64; i++) begin
            if (fixed && wrapb) nx = (a & ~mask) | ((a + 1) & mask);
            else nx = (a + 1) % 64;
            gap = fixed && !wrapb && (i != n - 1) && (nx % 16 == 0);
            for (int h = 0; h < hold; h++) begin
                if (idx < 64) begin
                    exp_oe[idx] = 1; exp_dq[idx] = memval(a);
                    exp_act[idx] = early && (h == hold - 1) && gap;
                    idx++;
                end
            end
            if (gap && idx < 64) begin
                exp_oe[idx] = 1; exp_dq[idx] = memval(a); exp_act[idx] = !early;
                idx++;
            end
            a = nx;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ep;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state: R1 R9 R13
        chk(dq_oe == 0, "R1 reset dq_oe", dq_oe, 0);
        chk(cfg_err == 0, "R10 reset cfg_err", cfg_err, 0);
        chk(rdy_wait == 1, "R9 reset ready pin", rdy_wait, 1);
        chk(launch_fall == 0, "R13 reset launch_fall", launch_fall, 0);
        for (int a = 0; a < DEPTH; a++) begin
            arr_we = 1; arr_waddr = AW'(a); arr_wdata = memval(a);
            tick();
        end
        arr_we = 0;

        // default configuration burst: latency 7, continuous, ready pin (R1 R2 R11)
        chip_en = 1; addr_valid = 1; start_addr = 6'd3;
        tick();
        addr_valid = 0;
        for (int t = 0; t < 10; t++) begin
            if (t == 6) chk(dq_oe == 0, "R1 default latency no data at t6", dq_oe, 0);
            if (t == 7) chk(dq_oe && dq_out == memval(3), "R1 default first word", dq_out, memval(3));
            if (t == 8) chk(dq_out == memval(4), "R5 default continuous step", dq_out, memval(4));
            chk(rdy_wait == 1, "R9 ready function pin", rdy_wait, 1);
            if (t < 9) tick();
        end
        chip_en = 0;
        tick();
        chk(dq_oe == 0, "R11 chip enable ends burst", dq_oe, 0);
        tick();

        // table walk
        foreach (VECS[v]) begin
            write_cfg(VECS[v].cfg);
            chk(cfg_err == 0, $sformatf("%s cfg legal", VECS[v].tag), cfg_err, 0);
            build_model(VECS[v].cfg, int'(VECS[v].addr));
            chip_en = 1; addr_valid = 1; start_addr = VECS[v].addr;
            tick();
            addr_valid = 0;
            for (int t = 0; t < NC; t++) begin
                ep = VECS[v].cfg[4] ? 1'b1 : (VECS[v].cfg[10] ? exp_act[t] : !exp_act[t]);
                chk(dq_oe == exp_oe[t], $sformatf("%s oe t=%0d", VECS[v].tag, t), dq_oe, exp_oe[t]);
                chk(dq_out == exp_dq[t], $sformatf("%s dq t=%0d", VECS[v].tag, t), dq_out, exp_dq[t]);
                chk(rdy_wait == ep, $sformatf("%s pin R9 t=%0d", VECS[v].tag, t), rdy_wait, ep);
                tick();
            end
            chip_en = 0;
            tick(); tick();
        end

        // configuration errors: R10
        write_cfg(16'h1749);
        chk(cfg_err == 1, "R10 latency2 hold2 early flagged", cfg_err, 1);
        chip_en = 1; addr_valid = 1; start_addr = 6'd2;
        tick();
        addr_valid = 0;
        for (int t = 0; t < 8; t++) begin
            chk(dq_oe == 0, "R10 burst refused", dq_oe, 0);
            tick();
        end
        chip_en = 0;
        write_cfg(16'h0C49);
        chk(cfg_err == 1, "R10 reserved latency code", cfg_err, 1);
        write_cfg(16'h1C4C);
        chk(cfg_err == 1, "R10 reserved length code", cfg_err, 1);
        write_cfg(16'h1CC9);
        chk(cfg_err == 1, "R10 reserved bit 7", cfg_err, 1);
        write_cfg(16'h1C49);
        chk(cfg_err == 0, "R10 legal word clears flag", cfg_err, 0);

        // write during burst ignored: R1
        chip_en = 1; addr_valid = 1; start_addr = 6'd5;
        tick();
        addr_valid = 0;
        cfg_we = 1; cfg_wdata = 16'h3809;
        tick();
        cfg_we = 0;
        chk(launch_fall == 0, "R1 write during burst ignored", launch_fall, 0);
        repeat (10) tick();
        addr_valid = 1; start_addr = 6'd40;
        tick();
        addr_valid = 0;
        tick(); tick();
        chk(dq_oe == 0, "R1 latency kept at 3 (t2)", dq_oe, 0);
        tick();
        chk(dq_oe && dq_out == memval(40), "R1 latency kept at 3 (t3)", dq_out, memval(40));
        chip_en = 0;
        tick(); tick();

        // edge select: R13
        write_cfg(16'h1C09);
        chk(launch_fall == 1, "R13 falling edge selected", launch_fall, 1);

        // asynchronous mode: R12
        write_cfg(16'h9C49);
        chip_en = 1; start_addr = 6'd20;
        #1;
        chk(dq_oe && dq_out == memval(20), "R12 async read", dq_out, memval(20));
        addr_valid = 1;
        tick();
        addr_valid = 0; start_addr = 6'd21;
        #1;
        chk(dq_oe && dq_out == memval(21), "R12 async follows address, no burst", dq_out, memval(21));
        chip_en = 0;
        #1;
        chk(dq_oe == 0, "R12 async released without chip enable", dq_oe, 0);
        tick();

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule